// File: doc/BRIEF.md
# Byte-Wide Repeat Filter

This block sits on a ring transmit path between the symbol-pair source and the 4B/5B encoder. Every byte clock it takes one 10-bit symbol pair, written as two 5-bit decoded symbols with the first symbol in bits 9:5. It then decides whether the pair may be repeated onto the ring. Idle traffic and well-formed frame traffic are passed through. Line states that are not allowed are replaced with idle. A frame that goes bad partway through is cut short with halt symbols followed by idle.

A frame fragment is a frame that drops back to idle before it has an ending delimiter. The filter replaces the pair that holds the stray idle with an idle pair. In the same cycle it raises a one-cycle gobble strobe, and the encoder uses that strobe to overwrite the pair it already holds with idle as well. Each pass through a repeating station therefore strips another pair from the fragment.

A parity-error flag replaces the incoming pair with an invalid pair before any filtering is done. A disable input takes the state machine out of the path, so that pairs are only delayed by one register.

Top module: `repeat_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `pair_o` is the idle pair 10'b1011110111, `gobble_o` is 0 and `state_o` is 2'b01.
- R2: `state_o` gives the state as 00 = repeat, 01 = idle, 10 = first halt and 11 = second halt. `state_o`, `pair_o` and `gobble_o` change together, one clock after the pair that caused the change.
- R3: Symbol codes are as follows. Data symbols have bit 4 clear. The control symbols are Q=10000, I=10111, H=10100, J=11100, K=10011, T=11101, R=10001 and S=11001. Every other code with bit 4 set is a violation. In the repeat state outside a frame, an I,I pair is passed. A J,K pair is passed and opens a frame. Every other pair comes out as I,I.
- R4: Inside a frame body, the following pairs pass unchanged: data,data; J,K; data,T; T,I; T followed by R, S or T. A T in either half ends the body. T,I returns the filter to outside-frame rules. The other T pairs enter the trailer.
- R5: In the trailer, a pair made only of R, S and T symbols passes and the filter stays in the trailer. Any other pair is handled by the outside-frame rules of R3.
- R6: Inside a body, each of the following counts as corruption: a Q, H or violation symbol in either half; R, S, or a J or K outside an exact J,K pair; or data or J or K after a leading T. On corruption the output is H,H (10'b1010010100) in state 10, then H,H in state 11, then I,I in state 01. The input is ignored during the two halt cycles.
- R7: In the idle state, every pair other than J,K comes out as I,I and the state stays 01. A J,K pair is passed, the state becomes 00 and a frame opens.
- R8: Inside a body, an I in the first half, or an I in the second half after a data symbol, is a fragment. The output is I,I with `gobble_o`=1 for exactly one cycle, in state 00. The filter then follows outside-frame rules.
- R9: When `par_err_i` is 1, the pair is replaced by 10'b1100011000 (two violation symbols) before filtering. Outside a frame this gives I,I. Inside a body it starts the halt sequence.
- R10: When `filt_off_i` is 1, the pair (after the replacement in R9) appears on `pair_o` one clock later unchanged, with `gobble_o`=0 and `state_o`=01. Frame tracking is cleared, so a J,K pair is needed before repeating resumes after the filter is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_i | input | 10 | Incoming symbol pair, first symbol in bits 9:5 |
| par_err_i | input | 1 | Parity error on the incoming pair |
| filt_off_i | input | 1 | Filter disable, pass-through when 1 |
| pair_o | output | 10 | Filtered symbol pair, registered |
| gobble_o | output | 1 | Strobe telling the encoder to turn its held pair into idle |
| state_o | output | 2 | Current filter state code |

## Verification
The bench feeds all 1024 pair values into each filter context: outside a frame, inside a body, in the trailer, in the idle state after a truncation, and with the filter disabled. It then follows each pair for two more cycles. A design that mixed up the precedence between a stray idle and a bad symbol would show up in two ways. It might gobble where it should halt. It might also let a T,I end pass as a fragment. If the halt counter were off, the bench would see either two H symbols or six of them instead of four. If frame tracking were not cleared, R and S symbols would leak after a trailer, or repeating would start again after the filter is enabled without any J,K pair. Parity-forced invalid pairs are sent both inside and outside frames, which shows that the replacement happens before the filter makes its decision.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] CODE_Q   = 5'b10000;
  localparam logic [SYM_W-1:0] CODE_I   = 5'b10111;
  localparam logic [SYM_W-1:0] CODE_H   = 5'b10100;
  localparam logic [SYM_W-1:0] CODE_J   = 5'b11100;
  localparam logic [SYM_W-1:0] CODE_K   = 5'b10011;
  localparam logic [SYM_W-1:0] CODE_T   = 5'b11101;
  localparam logic [SYM_W-1:0] CODE_R   = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_S   = 5'b11001;
  localparam logic [SYM_W-1:0] CODE_INV = 5'b11000;

  typedef enum logic [1:0] {
    ST_REPEAT = 2'b00,
    ST_IDLE   = 2'b01,
    ST_HALT1  = 2'b10,
    ST_HALT2  = 2'b11
  } rf_state_e;

  typedef enum logic [1:0] {
    PH_OUT  = 2'b00,
    PH_BODY = 2'b01,
    PH_TAIL = 2'b10
  } rf_phase_e;

  typedef enum logic [3:0] {
    K_DATA, K_Q, K_I, K_H, K_J, K_K, K_T, K_R, K_S, K_V
  } sym_kind_e;

  typedef enum logic [1:0] {
    EMIT_PASS = 2'b00,
    EMIT_IDLE = 2'b01,
    EMIT_HALT = 2'b10
  } rf_emit_e;

  function automatic logic is_line_bad(sym_kind_e k);
    return (k == K_Q) || (k == K_H) || (k == K_V);
  endfunction

  function automatic logic is_trailer(sym_kind_e k);
    return (k == K_T) || (k == K_R) || (k == K_S);
  endfunction
endpackage

// File: rtl/rf_sym_class.sv
module rf_sym_class
  import rf_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output sym_kind_e        kind_o
);
  always_comb begin
    if (!sym_i[SYM_W-1]) begin
      kind_o = K_DATA;
    end else begin
      unique case (sym_i)
        CODE_Q:  kind_o = K_Q;
        CODE_I:  kind_o = K_I;
        CODE_H:  kind_o = K_H;
        CODE_J:  kind_o = K_J;
        CODE_K:  kind_o = K_K;
        CODE_T:  kind_o = K_T;
        CODE_R:  kind_o = K_R;
        CODE_S:  kind_o = K_S;
        default: kind_o = K_V;
      endcase
    end
  end
endmodule

// File: rtl/rf_pair_class.sv
module rf_pair_class
  import rf_pkg::*;
#(
  parameter int N_SYM = 2
) (
  input  logic [N_SYM*SYM_W-1:0] pair_i,
  output sym_kind_e              kind_hi_o,
  output sym_kind_e              kind_lo_o
);
  sym_kind_e kinds [N_SYM];

  for (genvar g = 0; g < N_SYM; g++) begin : g_sym
    rf_sym_class u_sym (
      .sym_i  (pair_i[g*SYM_W +: SYM_W]),
      .kind_o (kinds[g])
    );
  end

  assign kind_hi_o = kinds[N_SYM-1];
  assign kind_lo_o = kinds[0];
endmodule

// File: rtl/rf_next.sv
module rf_next
  import rf_pkg::*;
(
  input  rf_state_e state_i,
  input  rf_phase_e phase_i,
  input  sym_kind_e hi_i,
  input  sym_kind_e lo_i,
  output rf_state_e state_o,
  output rf_phase_e phase_o,
  output rf_emit_e  emit_o,
  output logic      gobble_o
);
  logic pr_jk, pr_ii, pr_tail;

  assign pr_jk   = (hi_i == K_J) && (lo_i == K_K);
  assign pr_ii   = (hi_i == K_I) && (lo_i == K_I);
  assign pr_tail = is_trailer(hi_i) && is_trailer(lo_i);

  // outcome of a pair seen inside a frame body
  typedef enum logic [1:0] {BO_PASS, BO_FRAG, BO_HALT} body_out_e;
  body_out_e body_out;
  rf_phase_e body_ph;

  always_comb begin
    body_out = BO_HALT;
    body_ph  = PH_OUT;
    if (is_line_bad(hi_i) || is_line_bad(lo_i)) begin
      body_out = BO_HALT;
    end else if (hi_i == K_I) begin
      body_out = BO_FRAG;
    end else if (hi_i == K_T) begin
      if (is_trailer(lo_i)) begin
        body_out = BO_PASS;
        body_ph  = PH_TAIL;
      end else if (lo_i == K_I) begin
        body_out = BO_PASS;
        body_ph  = PH_OUT;
      end
    end else if (pr_jk) begin
      body_out = BO_PASS;
      body_ph  = PH_BODY;
    end else if (hi_i == K_DATA) begin
      if (lo_i == K_DATA) begin
        body_out = BO_PASS;
        body_ph  = PH_BODY;
      end else if (lo_i == K_T) begin
        body_out = BO_PASS;
        body_ph  = PH_TAIL;
      end else if (lo_i == K_I) begin
        body_out = BO_FRAG;
      end
    end
  end

  always_comb begin
    state_o  = state_i;
    phase_o  = phase_i;
    emit_o   = EMIT_IDLE;
    gobble_o = 1'b0;
    unique case (state_i)
      ST_HALT1: begin
        state_o = ST_HALT2;
        phase_o = PH_OUT;
        emit_o  = EMIT_HALT;
      end
      ST_HALT2: begin
        state_o = ST_IDLE;
        phase_o = PH_OUT;
        emit_o  = EMIT_IDLE;
      end
      ST_IDLE: begin
        if (pr_jk) begin
          state_o = ST_REPEAT;
          phase_o = PH_BODY;
          emit_o  = EMIT_PASS;
        end
      end
      default: begin
        if (phase_i == PH_BODY) begin
          unique case (body_out)
            BO_PASS: begin
              emit_o  = EMIT_PASS;
              phase_o = body_ph;
            end
            BO_FRAG: begin
              emit_o   = EMIT_IDLE;
              gobble_o = 1'b1;
              phase_o  = PH_OUT;
            end
            default: begin
              state_o = ST_HALT1;
              phase_o = PH_OUT;
              emit_o  = EMIT_HALT;
            end
          endcase
        end else if ((phase_i == PH_TAIL) && pr_tail) begin
          emit_o  = EMIT_PASS;
          phase_o = PH_TAIL;
        end else if (pr_jk) begin
          emit_o  = EMIT_PASS;
          phase_o = PH_BODY;
        end else begin
          emit_o  = pr_ii ? EMIT_PASS : EMIT_IDLE;
          phase_o = PH_OUT;
        end
      end
    endcase
  end
endmodule

// File: rtl/repeat_filter.sv
module repeat_filter
  import rf_pkg::*;
#(
  parameter int N_SYM = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SYM*SYM_W-1:0] pair_i,
  input  logic                   par_err_i,
  input  logic                   filt_off_i,
  output logic [N_SYM*SYM_W-1:0] pair_o,
  output logic                   gobble_o,
  output logic [1:0]             state_o
);
  localparam int PAIR_W = N_SYM * SYM_W;
  localparam logic [PAIR_W-1:0] PAIR_II  = {N_SYM{CODE_I}};
  localparam logic [PAIR_W-1:0] PAIR_HH  = {N_SYM{CODE_H}};
  localparam logic [PAIR_W-1:0] PAIR_INV = {N_SYM{CODE_INV}};

  logic [PAIR_W-1:0] eff_pair, pair_q, pair_n;
  sym_kind_e         kind_hi, kind_lo;
  rf_state_e         state_q, state_n;
  rf_phase_e         phase_q, phase_n;
  rf_emit_e          emit;
  logic              gob_q, gob_n;

  assign eff_pair = par_err_i ? PAIR_INV : pair_i;

  rf_pair_class #(.N_SYM(N_SYM)) u_class (
    .pair_i    (eff_pair),
    .kind_hi_o (kind_hi),
    .kind_lo_o (kind_lo)
  );

  rf_next u_next (
    .state_i  (state_q),
    .phase_i  (phase_q),
    .hi_i     (kind_hi),
    .lo_i     (kind_lo),
    .state_o  (state_n),
    .phase_o  (phase_n),
    .emit_o   (emit),
    .gobble_o (gob_n)
  );

  always_comb begin
    unique case (emit)
      EMIT_PASS: pair_n = eff_pair;
      EMIT_HALT: pair_n = PAIR_HH;
      default:   pair_n = PAIR_II;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_OUT;
      pair_q  <= PAIR_II;
      gob_q   <= 1'b0;
    end else if (filt_off_i) begin
      state_q <= ST_IDLE;
      phase_q <= PH_OUT;
      pair_q  <= eff_pair;
      gob_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      pair_q  <= pair_n;
      gob_q   <= gob_n;
    end
  end

  assign pair_o   = pair_q;
  assign gobble_o = gob_q;
  assign state_o  = state_q;
endmodule

// File: rtl/rf_chk.sv
module rf_chk (
  input logic       clk,
  input logic       rst,
  input logic [9:0] pair_i,
  input logic       par_err_i,
  input logic       filt_off_i,
  input logic [9:0] pair_o,
  input logic       gobble_o,
  input logic [1:0] state_o
);
  localparam logic [9:0] C_II  = 10'b1011110111;
  localparam logic [9:0] C_HH  = 10'b1010010100;
  localparam logic [9:0] C_JK  = 10'b1110010011;
  localparam logic [9:0] C_INV = 10'b1100011000;

  assert_halt1_to_halt2_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10 && !filt_off_i) |=> (state_o == 2'b11));

  assert_halt2_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b11) |=> (state_o == 2'b01 && (filt_off_i || pair_o == C_II)) || $past(filt_off_i));

  assert_halt_emits_h_R6: assert property (@(posedge clk) disable iff (rst)
    state_o[1] |-> (pair_o == C_HH));

  assert_gobble_idle_R8: assert property (@(posedge clk) disable iff (rst)
    gobble_o |-> (state_o == 2'b00 && pair_o == C_II));

  assert_gobble_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    gobble_o |=> !gobble_o);

  assert_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    filt_off_i |=> (!gobble_o && state_o == 2'b01 &&
                    pair_o == ($past(par_err_i) ? C_INV : $past(pair_i))));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && !filt_off_i && (par_err_i || pair_i != C_JK))
      |=> (state_o == 2'b01 && pair_o == C_II));
endmodule

bind repeat_filter rf_chk u_chk (.*);

// File: tb/sim_repeat_filter.sv
module sim_repeat_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] pair_i = 10'b1011110111;
  logic       par_err_i = 1'b0;
  logic       filt_off_i = 1'b0;
  logic [9:0] pair_o;
  logic       gobble_o;
  logic [1:0] state_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  repeat_filter u0 (
    .clk(clk), .rst(rst), .pair_i(pair_i), .par_err_i(par_err_i),
    .filt_off_i(filt_off_i), .pair_o(pair_o), .gobble_o(gobble_o),
    .state_o(state_o)
  );

  localparam logic [9:0] P_II  = 10'b1011110111;
  localparam logic [9:0] P_HH  = 10'b1010010100;
  localparam logic [9:0] P_JK  = 10'b1110010011;
  localparam logic [9:0] P_INV = 10'b1100011000;
  localparam logic [9:0] P_DD  = 10'b0000000101;
  localparam logic [9:0] P_TI  = 10'b1110110111;
  localparam logic [9:0] P_TT  = 10'b1110111101;

  localparam int KD = 0, KQ = 1, KI = 2, KH = 3, KJ = 4, KK = 5, KT = 6, KR = 7, KS = 8, KV = 9;

  // model state: 0 repeat, 1 idle, 2 halt1, 3 halt2; phase 0 out, 1 body, 2 trailer
  int m_st = 1;
  int m_ph = 0;
  logic [9:0] e_pair = P_II;
  logic       e_gob = 1'b0;

  function automatic int kind_of(logic [4:0] s);
    if (!s[4]) return KD;
    case (s)
      5'b10000: return KQ;
      5'b10111: return KI;
      5'b10100: return KH;
      5'b11100: return KJ;
      5'b10011: return KK;
      5'b11101: return KT;
      5'b10001: return KR;
      5'b11001: return KS;
      default:  return KV;
    endcase
  endfunction

  function automatic bit trl(int k);
    return k == KT || k == KR || k == KS;
  endfunction

  task automatic check(input string tag);
    total++;
    if (pair_o !== e_pair || gobble_o !== e_gob || state_o !== 2'(m_st)) begin
      bad++;
      $display("FAIL %s: got pair=%b gob=%b st=%0d, expected pair=%b gob=%b st=%0d",
               tag, pair_o, gobble_o, state_o, e_pair, e_gob, m_st);
    end
  endtask

  task automatic step(input logic [9:0] p, input logic pe, input logic off, input string tag);
    logic [9:0] eff;
    int h, l, oc, np;
    bit jk, ii;
    pair_i = p; par_err_i = pe; filt_off_i = off;
    eff = pe ? P_INV : p;
    h = kind_of(eff[9:5]);
    l = kind_of(eff[4:0]);
    jk = (h == KJ) && (l == KK);
    ii = (h == KI) && (l == KI);
    e_gob = 1'b0;
    if (off) begin
      e_pair = eff; m_st = 1; m_ph = 0;
    end else if (m_st == 2) begin
      e_pair = P_HH; m_st = 3;
    end else if (m_st == 3) begin
      e_pair = P_II; m_st = 1;
    end else if (m_st == 1) begin
      if (jk) begin e_pair = eff; m_st = 0; m_ph = 1; end
      else e_pair = P_II;
    end else if (m_ph == 1) begin
      oc = 2; np = 0;   // 0 pass, 1 fragment, 2 halt
      if (h == KQ || h == KH || h == KV || l == KQ || l == KH || l == KV) oc = 2;
      else if (h == KI) oc = 1;
      else if (h == KT) begin
        if (trl(l)) begin oc = 0; np = 2; end
        else if (l == KI) begin oc = 0; np = 0; end
      end else if (jk) begin oc = 0; np = 1; end
      else if (h == KD) begin
        if (l == KD) begin oc = 0; np = 1; end
        else if (l == KT) begin oc = 0; np = 2; end
        else if (l == KI) oc = 1;
      end
      if (oc == 0) begin e_pair = eff; m_ph = np; end
      else if (oc == 1) begin e_pair = P_II; e_gob = 1'b1; m_ph = 0; end
      else begin e_pair = P_HH; m_st = 2; m_ph = 0; end
    end else if (m_ph == 2 && trl(h) && trl(l)) begin
      e_pair = eff;
    end else if (jk) begin
      e_pair = eff; m_ph = 1;
    end else begin
      e_pair = P_II; m_ph = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic flush();
    repeat (3) step(P_II, 1'b0, 1'b0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    m_st = 1; e_pair = P_II; e_gob = 1'b0;
    check("R1");
    rst = 1'b0;
    step(P_II, 1'b0, 1'b0, "R1");

    // R3: every pair outside a frame, in the repeat state
    for (int p = 0; p < 1024; p++) begin
      flush();
      step(P_JK, 1'b0, 1'b0, "R7");
      step(P_TI, 1'b0, 1'b0, "R4");
      step(10'(p), 1'b0, 1'b0, "R3");
      step(P_II, 1'b0, 1'b0, "R3");
    end

    // R4 / R6 / R8: every pair inside a frame body
    for (int p = 0; p < 1024; p++) begin
      flush();
      step(P_JK, 1'b0, 1'b0, "R7");
      step(P_DD, 1'b0, 1'b0, "R4");
      step(10'(p), 1'b0, 1'b0, "R6");
      step(P_II, 1'b0, 1'b0, "R8");
      step(P_II, 1'b0, 1'b0, "R6");
    end

    // R5: every pair in the trailer
    for (int p = 0; p < 1024; p++) begin
      flush();
      step(P_JK, 1'b0, 1'b0, "R7");
      step(P_TT, 1'b0, 1'b0, "R4");
      step(10'(p), 1'b0, 1'b0, "R5");
      step(P_II, 1'b0, 1'b0, "R5");
    end

    // R7: every pair in the idle state after a truncation (R2 state sequence)
    for (int p = 0; p < 1024; p++) begin
      flush();
      step(P_JK, 1'b0, 1'b0, "R7");
      step(P_HH, 1'b0, 1'b0, "R2");
      step(P_DD, 1'b0, 1'b0, "R2");
      step(P_JK, 1'b0, 1'b0, "R6");
      step(10'(p), 1'b0, 1'b0, "R7");
      step(P_DD, 1'b0, 1'b0, "R7");
    end

    // R9: parity-forced pairs inside and outside a frame
    for (int p = 0; p < 1024; p += 16) begin
      flush();
      step(10'(p), 1'b1, 1'b0, "R9");
      step(P_JK, 1'b0, 1'b0, "R9");
      step(10'(p), 1'b1, 1'b0, "R9");
      step(P_II, 1'b0, 1'b0, "R9");
    end

    // R10: disabled pass-through, then re-enable needs J,K
    for (int p = 0; p < 1024; p++) begin
      step(10'(p), 1'(p[0] ^ p[5]), 1'b1, "R10");
    end
    step(P_DD, 1'b0, 1'b0, "R10");
    step(P_JK, 1'b0, 1'b0, "R10");
    step(P_DD, 1'b0, 1'b0, "R10");
    step(P_JK, 1'b0, 1'b1, "R10");
    step(P_DD, 1'b0, 1'b0, "R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule